// File: doc/BRIEF.md
# Speculative Load Conflict Buffer

This block lets a scheduler hoist a load above stores whose addresses are not yet known to differ from the load's address. When a speculative load issues, it claims a slot in a small fully associative table. The slot holds the load's start address, its access size and the number of the register the load writes. Every later store compares its own byte range against all occupied slots at once and taints each slot it overlaps. At the point where the load would have issued in program order, a check names the same destination register. The table looks the slot up, reports whether recovery code must run, and frees the slot on the same clock edge.

A check whose register has no slot also asks for recovery. That covers loads pushed out when the table was full, so such a load can never be trusted by mistake. A speculative load to a register that already owns a slot reuses that slot and starts it clean. When the table is full and the register has no slot, a round-robin victim pointer chooses the slot to give up.

Each slot is a three-state machine. The states are FREE, CLEAN and TAINTED. The transitions are:
- CLAIM: from any state to CLEAN, when a load allocates the slot.
- TAINT: from CLEAN to TAINTED, when a store overlaps the slot.
- RELEASE: from CLEAN or TAINTED to FREE, when a check hits the slot.

CLAIM takes priority over RELEASE, and RELEASE takes priority over TAINT.

Top module: `spec_load_buffer`

## Requirements
- R1: After reset every slot is FREE, so a check on any register reports hit=0, conflict=0, repair=1.
- R2: A speculative load claims a slot tagged with its register number. A later check on that register with no overlapping store in between reports hit=1, conflict=0, repair=0.
- R3: The size code gives the access length: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. A store whose byte range overlaps a held load's byte range taints that slot, and a check on it reports hit=1, conflict=1, repair=1.
- R4: A store whose byte range only touches a held load's range, ending just before it or starting just after it, leaves the slot CLEAN.
- R5: One store is compared against all occupied slots at once. It taints every slot it overlaps and no other slot, and it does not change which slots are occupied.
- R6: A check that hits frees its slot at the clock edge that ends the check cycle, so a second check on the same register misses.
- R7: A check that misses reports hit=0, conflict=0, repair=1.
- R8: A speculative load to a register that already holds a slot overwrites that slot's address and size and returns it to CLEAN.
- R9: When all slots are occupied and the register is new, the load takes the slot at the round-robin victim pointer. The pointer starts at slot 0 after reset, and after each eviction it moves on to the next slot. A later check on the evicted register misses and therefore reports repair.
- R10: A store and a speculative load in the same cycle act store first: the store taints older slots but not the slot the load claims.
- R11: A check and a store in the same cycle: the check reports the slot as it stood before the store, and the slot is freed.
- R12: A check and a speculative load naming the same register in the same cycle: the check reports the old slot, and the new load then holds that slot CLEAN.
- R13: A TAINTED slot stays TAINTED until a check frees it or a load reclaims it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Speculative load issues this cycle |
| ld_addr | input | ADDR_W | Start byte address of the load |
| ld_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| ld_tag | input | TAG_W | Destination register number of the load |
| st_valid | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Start byte address of the store |
| st_size | input | 2 | Store size code, same encoding as the load size code |
| chk_valid | input | 1 | Check issues this cycle |
| chk_tag | input | TAG_W | Register number named by the check |
| chk_hit | output | 1 | A slot for chk_tag was found (combinational) |
| chk_conflict | output | 1 | The found slot was TAINTED |
| chk_repair | output | 1 | Recovery required (miss or conflict) |

## Verification
Three pairs of operations can land in the same cycle:
- A store beside a load. Provoked by issuing the load with an address the store overlaps, while an older slot also overlaps the store. It is judged by the older register reporting a conflict and the new register reporting clean.
- A check beside a store that overlaps the checked slot. It is judged by a clean report followed by a miss.
- A check beside a reload of the same register. It is judged by a tainted report and then a clean hit on the next check.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_CLEAN   = 2'd1,
        SLOT_TAINTED = 2'd2
    } slot_state_e;

    typedef logic [1:0] size_code_t;

    // Length in bytes for a size code: 1, 2, 4 or 8.
    function automatic logic [3:0] span_bytes(input size_code_t code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/slb_entry.sv
module slb_entry
    import slb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              release_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  size_code_t        ld_size_i,
    input  logic [TAG_W-1:0]  ld_tag_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  size_code_t        st_size_i,
    output logic              valid_o,
    output logic              tainted_o,
    output logic [TAG_W-1:0]  tag_o
);

    localparam int EXT_W = ADDR_W + 1;

    slot_state_e       state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    size_code_t        size_q;
    logic [TAG_W-1:0]  tag_q;

    logic [EXT_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic             st_overlap;

    // Byte ranges are half-open [lo, hi); one extra bit avoids wrap.
    always_comb begin
        ld_lo = {1'b0, base_q};
        ld_hi = ld_lo + {{(EXT_W-4){1'b0}}, span_bytes(size_q)};
        st_lo = {1'b0, st_addr_i};
        st_hi = st_lo + {{(EXT_W-4){1'b0}}, span_bytes(st_size_i)};
        st_overlap = st_valid_i && (ld_lo < st_hi) && (st_lo < ld_hi);
    end

    // Next state: claim beats release, release beats taint.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc_i) state_d = SLOT_CLEAN;
            end
            SLOT_CLEAN: begin
                if (alloc_i)         state_d = SLOT_CLEAN;
                else if (release_i)  state_d = SLOT_FREE;
                else if (st_overlap) state_d = SLOT_TAINTED;
            end
            SLOT_TAINTED: begin
                if (alloc_i)        state_d = SLOT_CLEAN;
                else if (release_i) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            tag_q  <= '0;
        end else if (alloc_i) begin
            base_q <= ld_addr_i;
            size_q <= ld_size_i;
            tag_q  <= ld_tag_i;
        end
    end

    always_comb begin
        valid_o   = (state_q != SLOT_FREE);
        tainted_o = (state_q == SLOT_TAINTED);
        tag_o     = tag_q;
    end

endmodule

// File: rtl/slb_alloc.sv
module slb_alloc #(
    parameter int N     = 8,
    parameter int TAG_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid_i,
    input  logic [TAG_W-1:0]         ld_tag_i,
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0][TAG_W-1:0]  tag_i,
    output logic [N-1:0]             sel_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]     same_tag;
    logic [N-1:0]     first_free;
    logic             table_full;
    logic             evict;
    logic [IDX_W-1:0] victim_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            same_tag[i] = valid_i[i] && (tag_i[i] == ld_tag_i);
        end
    end

    // Lowest-numbered free slot, one-hot.
    always_comb begin
        first_free = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) first_free = N'(1) << i;
        end
    end

    always_comb begin
        table_full = &valid_i;
        evict      = ld_valid_i && !(|same_tag) && table_full;
        sel_o      = '0;
        if (ld_valid_i) begin
            if (|same_tag)        sel_o = same_tag;
            else if (!table_full) sel_o = first_free;
            else                  sel_o[victim_q] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (evict) begin
            victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
        end
    end

endmodule

// File: rtl/slb_lookup.sv
module slb_lookup #(
    parameter int N     = 8,
    parameter int TAG_W = 7
) (
    input  logic                     chk_valid_i,
    input  logic [TAG_W-1:0]         chk_tag_i,
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0]             tainted_i,
    input  logic [N-1:0][TAG_W-1:0]  tag_i,
    output logic [N-1:0]             release_o,
    output logic                     hit_o,
    output logic                     conflict_o,
    output logic                     repair_o
);

    logic [N-1:0] match;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            match[i] = chk_valid_i && valid_i[i] && (tag_i[i] == chk_tag_i);
        end
        release_o  = match;
        hit_o      = |match;
        conflict_o = |(match & tainted_i);
        repair_o   = chk_valid_i && (!hit_o || conflict_o);
    end

endmodule

// File: rtl/spec_load_buffer.sv
module spec_load_buffer
    import slb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_hit,
    output logic              chk_conflict,
    output logic              chk_repair
);

    logic [N-1:0]            valid_vec;
    logic [N-1:0]            dirty_vec;
    logic [N-1:0][TAG_W-1:0] tag_arr;
    logic [N-1:0]            alloc_sel;
    logic [N-1:0]            release_vec;

    slb_alloc #(.N(N), .TAG_W(TAG_W)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid_i (ld_valid),
        .ld_tag_i   (ld_tag),
        .valid_i    (valid_vec),
        .tag_i      (tag_arr),
        .sel_o      (alloc_sel)
    );

    slb_lookup #(.N(N), .TAG_W(TAG_W)) u_lookup (
        .chk_valid_i (chk_valid),
        .chk_tag_i   (chk_tag),
        .valid_i     (valid_vec),
        .tainted_i   (dirty_vec),
        .tag_i       (tag_arr),
        .release_o   (release_vec),
        .hit_o       (chk_hit),
        .conflict_o  (chk_conflict),
        .repair_o    (chk_repair)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        slb_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_sel[g]),
            .release_i  (release_vec[g]),
            .ld_addr_i  (ld_addr),
            .ld_size_i  (ld_size),
            .ld_tag_i   (ld_tag),
            .st_valid_i (st_valid),
            .st_addr_i  (st_addr),
            .st_size_i  (st_size),
            .valid_o    (valid_vec[g]),
            .tainted_o  (dirty_vec[g]),
            .tag_o      (tag_arr[g])
        );
    end

endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_valid,
    input logic         st_valid,
    input logic         chk_valid,
    input logic         chk_hit,
    input logic         chk_conflict,
    input logic         chk_repair,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] dirty_vec,
    input logic [N-1:0] alloc_sel
);

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0));

    p_load_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (valid_vec != '0));

    p_conflict_implies_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_conflict |-> (chk_hit && chk_repair));

    p_store_keeps_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !ld_valid && !chk_valid) |=>
            ($countones(valid_vec) == $past($countones(valid_vec))));

    p_check_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_hit && !ld_valid) |=>
            ($countones(valid_vec) == $past($countones(valid_vec)) - 1));

    p_miss_repair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_hit) |-> (chk_repair && !chk_conflict));

    p_single_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($countones(alloc_sel) == 1));

    p_taint_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && !chk_valid) |=> ((dirty_vec & $past(dirty_vec)) == $past(dirty_vec)));

endmodule

bind spec_load_buffer slb_checker #(.N(N)) u_slb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_valid     (ld_valid),
    .st_valid     (st_valid),
    .chk_valid    (chk_valid),
    .chk_hit      (chk_hit),
    .chk_conflict (chk_conflict),
    .chk_repair   (chk_repair),
    .valid_vec    (valid_vec),
    .dirty_vec    (dirty_vec),
    .alloc_sel    (alloc_sel)
);

// File: tb/spec_load_buffer_test.sv
module spec_load_buffer_test;

    localparam int N      = 8;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic              chk_valid = 1'b0;
    logic [TAG_W-1:0]  chk_tag = '0;
    logic              chk_hit, chk_conflict, chk_repair;

    int n_run  = 0;
    int n_fail = 0;
    logic got_hit, got_conf, got_rep;
    logic done = 1'b0;

    always #5 clk = ~clk;

    spec_load_buffer #(.N(N), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size), .ld_tag(ld_tag),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_hit(chk_hit), .chk_conflict(chk_conflict), .chk_repair(chk_repair)
    );

    task automatic idle_inputs();
        ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle with any mix of load, store and check; captures the check result.
    task automatic step(input logic lv, input int la, input int ls, input int lt,
                        input logic sv, input int sa, input int ss,
                        input logic cv, input int ct);
        @(negedge clk);
        ld_valid = lv; ld_addr = ADDR_W'(la); ld_size = 2'(ls); ld_tag = TAG_W'(lt);
        st_valid = sv; st_addr = ADDR_W'(sa); st_size = 2'(ss);
        chk_valid = cv; chk_tag = TAG_W'(ct);
        #1;
        got_hit = chk_hit; got_conf = chk_conflict; got_rep = chk_repair;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic load(input int a, input int s, input int t);
        step(1'b1, a, s, t, 1'b0, 0, 0, 1'b0, 0);
    endtask

    task automatic store(input int a, input int s);
        step(1'b0, 0, 0, 0, 1'b1, a, s, 1'b0, 0);
    endtask

    task automatic expect_chk(input string req, input logic eh, input logic ec, input logic er);
        n_run++;
        if (got_hit !== eh || got_conf !== ec || got_rep !== er) begin
            n_fail++;
            $display("FAIL %s: hit/conflict/repair got %b%b%b expected %b%b%b",
                     req, got_hit, got_conf, got_rep, eh, ec, er);
        end
    endtask

    task automatic check_tag(input string req, input int t,
                             input logic eh, input logic ec, input logic er);
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 1'b1, t);
        expect_chk(req, eh, ec, er);
    endtask

    task automatic t_reset();
        do_reset();
        check_tag("R1 empty after reset", 3, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_basic();
        do_reset();
        load(32'h40, 2, 5);
        check_tag("R2 clean hit", 5, 1'b1, 1'b0, 1'b0);
        check_tag("R6 second check misses", 5, 1'b0, 1'b0, 1'b1);
        check_tag("R7 unknown tag", 99, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_sizes();
        do_reset();
        load(32'h100, 2, 1);            // 0x100..0x103
        store(32'h103, 0);              // last byte
        check_tag("R3 4-byte overlap", 1, 1'b1, 1'b1, 1'b1);
        load(32'h300, 3, 2);            // 0x300..0x307
        store(32'h307, 0);
        check_tag("R3 8-byte overlap", 2, 1'b1, 1'b1, 1'b1);
        load(32'h200, 1, 3);            // 0x200..0x201
        store(32'h202, 1);              // just after
        store(32'h1F8, 3);              // 0x1F8..0x1FF just before
        check_tag("R4 adjacent stores", 3, 1'b1, 1'b0, 1'b0);
        load(32'h500, 0, 4);
        store(32'h4FF, 1);              // 0x4FF..0x500
        check_tag("R3 1-byte overlap", 4, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_assoc();
        do_reset();
        load(32'h400, 2, 1);
        load(32'h404, 2, 2);
        load(32'h500, 2, 3);
        store(32'h402, 2);              // 0x402..0x405
        check_tag("R5 first marked", 1, 1'b1, 1'b1, 1'b1);
        check_tag("R5 second marked", 2, 1'b1, 1'b1, 1'b1);
        check_tag("R5 third untouched", 3, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_overwrite();
        do_reset();
        load(32'h600, 2, 4);
        store(32'h600, 0);
        store(32'h900, 0);              // unrelated; R13 keeps taint
        load(32'h700, 2, 4);
        check_tag("R8 reload clears taint", 4, 1'b1, 1'b0, 1'b0);
        load(32'h800, 2, 6);
        store(32'h800, 0);
        store(32'hA00, 0);
        check_tag("R13 taint persists", 6, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_evict();
        do_reset();
        for (int i = 0; i < N; i++) load(32'h1000 + 16 * i, 2, 10 + i);
        load(32'h2000, 2, 20);          // evicts slot 0 (tag 10)
        check_tag("R9 first victim", 10, 1'b0, 1'b0, 1'b1);
        load(32'h2010, 2, 21);          // evicts slot 1 (tag 11)
        check_tag("R9 second victim", 11, 1'b0, 1'b0, 1'b1);
        check_tag("R9 survivor", 12, 1'b1, 1'b0, 1'b0);
        check_tag("R9 new entry", 20, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        load(32'h900, 2, 7);
        // R10: store and load in the same cycle, store first
        step(1'b1, 32'h900, 2, 8, 1'b1, 32'h900, 0, 1'b0, 0);
        check_tag("R10 older marked", 7, 1'b1, 1'b1, 1'b1);
        check_tag("R10 new not marked", 8, 1'b1, 1'b0, 1'b0);
        // R11: check and overlapping store together
        load(32'hA00, 2, 9);
        step(1'b0, 0, 0, 0, 1'b1, 32'hA00, 0, 1'b1, 9);
        expect_chk("R11 report before store", 1'b1, 1'b0, 1'b0);
        check_tag("R11 entry freed", 9, 1'b0, 1'b0, 1'b1);
        // R12: check and reload of the same register together
        load(32'hB00, 2, 11);
        store(32'hB01, 0);
        step(1'b1, 32'hC00, 2, 11, 1'b0, 0, 0, 1'b1, 11);
        expect_chk("R12 old entry reported", 1'b1, 1'b1, 1'b1);
        check_tag("R12 new entry clean", 11, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sizes();
        t_assoc();
        t_overwrite();
        t_evict();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule